// File: doc/BRIEF.md
# Per-Hart Software Interrupt Doorbell

This block raises one software interrupt line per hart in a multi-hart cluster. Software on any hart writes a 32-bit word into the register that belongs to the target hart, and bit 0 of that word raises the target's interrupt line. The registers sit at a 4-byte stride from the block base. The register for hart lane `i` is at byte offset `4*i`, so the lane index is the offset shifted right by two. The block is intended for inter-processor signalling.

A static parameter `MODE` picks one of two variants.

- **Machine variant (`IPI_MACHINE`).** Each register is a plain read/write bit. Writing 0 to it lowers the line, and reading it returns the line state.
- **Supervisor variant (`IPI_SUPER`).** The block behaves as a set-only doorbell. Writing 0 has no effect and reads return zero. The line is lowered only by a per-hart acknowledge input, `hart_ack`, which the receiving hart drives when it takes the interrupt.

Each lane is a two-state machine with the states `LANE_IDLE` and `LANE_RAISED`. It has the following transitions:

- **SET** (`LANE_IDLE`→`LANE_RAISED`): a valid write to the lane with bit 0 set.
- **WCLR** (`LANE_RAISED`→`LANE_IDLE`): in the machine variant only, a valid write to the lane with bit 0 clear.
- **ACK** (`LANE_RAISED`→`LANE_IDLE`): in the supervisor variant only, `hart_ack` for that lane with no set in the same cycle.
- **HOLD**: any other cycle, in which the lane keeps its state.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset every `irq_o` bit is 0 and `bus_rdata` is 0.
- R2: A write (`bus_req`=1, `bus_we`=1, `bus_be`=4'hF) to byte offset `4*i`, with `i` < `NUM_HARTS` and `bus_wdata[0]`=1, sets `irq_o[i]` on the next clock edge in both variants. Bits 31:1 of the write data are ignored, and the other lanes are unchanged.
- R3: In the machine variant, such a write with `bus_wdata[0]`=0 clears `irq_o[i]` on the next edge.
- R4: In the supervisor variant, such a write with `bus_wdata[0]`=0 leaves `irq_o[i]` unchanged.
- R5: In the machine variant, a read (`bus_req`=1, `bus_we`=0, `bus_be`=4'hF) of offset `4*i` places `{31'b0, irq_o[i]}` on `bus_rdata` in the cycle after the request.
- R6: In the supervisor variant, `bus_rdata` is always 0.
- R7: An access whose offset has bits 1:0 not equal to 0, whose lane index is `NUM_HARTS` or greater, or whose `bus_be` is not 4'hF returns 0 on a read and changes no line on a write. `bus_rdata` is also 0 in any cycle that follows a cycle with no read.
- R8: In the supervisor variant, `hart_ack[i]`=1 clears `irq_o[i]` on the next edge. If a set write to lane `i` occurs in the same cycle, the set wins.
- R9: In the machine variant, `hart_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| hart_ack | input | NUM_HARTS | Per-lane acknowledge (supervisor variant) |
| irq_o | output | NUM_HARTS | Per-lane software interrupt lines |

## Verification
The embedded assertions check the per-lane transitions on every cycle in both variants:

- a set always raises the line;
- a machine-variant write of 0 drops it;
- a supervisor-variant write of 0 holds it;
- an acknowledge drops the line in supervisor mode and is inert in machine mode;
- no more than one lane is selected per access;
- the read data is zero whenever no valid read preceded it.

Only the bench's scenarios can show the address map. Its sweeps over every offset and both data values, in both variants at once, show that the lane a write reaches is the one at `offset/4`, that readback returns that lane's bit, and that partial byte enables or out-of-range offsets are silently dropped.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic {
        IPI_MACHINE = 1'b0,
        IPI_SUPER   = 1'b1
    } ipi_mode_e;

    typedef enum logic {
        LANE_IDLE   = 1'b0,
        LANE_RAISED = 1'b1
    } lane_state_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 6,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    input  logic                 wbit,
    output logic [NUM_HARTS-1:0] set_sel,
    output logic [NUM_HARTS-1:0] wclr_sel,
    output logic                 rd_hit,
    output logic [IDX_W-1:0]     rd_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              in_range;
    logic              legal;

    assign word     = bus_addr[ADDR_W-1:2];
    assign in_range = (int'(word) < NUM_HARTS);
    assign legal    = bus_req && (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF) && in_range;
    assign rd_hit   = legal && !bus_we;
    assign rd_idx   = word[IDX_W-1:0];

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
        assign set_sel[i]  = legal && bus_we &&  wbit && (word == WORD_W'(i));
        assign wclr_sel[i] = legal && bus_we && !wbit && (word == WORD_W'(i));
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_sel | wclr_sel)); // R7
    AST_BAD_ADDR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00 || bus_be != 4'hF) |-> ((set_sel | wclr_sel) == '0 && !rd_hit)); // R7
endmodule

// File: rtl/ipi_lane.sv
module ipi_lane
    import ipi_pkg::*;
#(
    parameter ipi_mode_e MODE = IPI_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wclr_i,
    input  logic ack_i,
    output logic irq
);
    lane_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE: begin
                if (set_i) state_d = LANE_RAISED;
            end
            LANE_RAISED: begin
                if (MODE == IPI_MACHINE) begin
                    if (wclr_i) state_d = LANE_IDLE;
                end else begin
                    if (ack_i && !set_i) state_d = LANE_IDLE;
                end
            end
            default: state_d = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == LANE_RAISED);
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq); // R2
    if (MODE == IPI_MACHINE) begin : g_mach_chk
        AST_MACH_WCLR: assert property (@(posedge clk) disable iff (!rst_n)
            wclr_i |=> !irq); // R3
        AST_MACH_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !set_i && !wclr_i) |=> $stable(irq)); // R9
    end else begin : g_sup_chk
        AST_SUP_WCLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr_i && !ack_i) |=> $stable(irq)); // R4
        AST_SUP_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !set_i) |=> !irq); // R8
    end
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_pkg::*;
#(
    parameter int        NUM_HARTS = 4,
    parameter int        ADDR_W    = 6,
    parameter ipi_mode_e MODE      = IPI_MACHINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_HARTS-1:0] hart_ack,
    output logic [NUM_HARTS-1:0] irq_o
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic [NUM_HARTS-1:0] set_sel;
    logic [NUM_HARTS-1:0] wclr_sel;
    logic                 rd_hit;
    logic [IDX_W-1:0]     rd_idx;

    ipi_decode #(
        .NUM_HARTS(NUM_HARTS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_req (bus_req),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .wbit    (bus_wdata[0]),
        .set_sel (set_sel),
        .wclr_sel(wclr_sel),
        .rd_hit  (rd_hit),
        .rd_idx  (rd_idx)
    );

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_lane
        ipi_lane #(.MODE(MODE)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_sel[i]),
            .wclr_i(wclr_sel[i]),
            .ack_i (hart_ack[i]),
            .irq   (irq_o[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_hit && MODE == IPI_MACHINE)
            bus_rdata <= {31'b0, irq_o[rd_idx]};
        else
            bus_rdata <= '0;
    end

    AST_RD_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (bus_rdata == '0)); // R7
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:1] == '0); // R5
    if (MODE == IPI_SUPER) begin : g_sup_rd
        AST_SUP_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit |=> (bus_rdata == '0)); // R6
    end
endmodule

// File: tb/tb_ipi_doorbell.sv
module tb_ipi_doorbell;
    import ipi_pkg::*;

    localparam int N  = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata_m, rdata_s;
    logic [N-1:0]  ack_m = '0, ack_s = '0;
    logic [N-1:0]  irq_m, irq_s;
    logic [N-1:0]  exp_m, exp_s;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ipi_doorbell #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(IPI_MACHINE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_m), .hart_ack(ack_m), .irq_o(irq_m));

    ipi_doorbell #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(IPI_SUPER)) dut_sup (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_s), .hart_ack(ack_s), .irq_o(irq_s));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input int a, input logic [3:0] b);
        return (a % 4 == 0) && (a / 4 < N) && (b == 4'hF);
    endfunction

    // One bus cycle plus acknowledges; model updated, outputs checked at the next negedge.
    task automatic step(input bit req, input bit we, input int a, input logic [31:0] d,
                        input logic [3:0] b, input logic [N-1:0] am, input logic [N-1:0] as_);
        logic [31:0] exp_rm;
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = AW'(a); bus_wdata = d; bus_be = b;
        ack_m = am; ack_s = as_;
        exp_rm = (req && !we && legal(a, b)) ? {31'b0, exp_m[a/4]} : 32'h0;
        for (int i = 0; i < N; i++) if (as_[i]) exp_s[i] = 1'b0;
        if (req && we && legal(a, b)) begin
            if (d[0]) begin
                exp_m[a/4] = 1'b1;
                exp_s[a/4] = 1'b1;
            end else begin
                exp_m[a/4] = 1'b0;
            end
        end
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; ack_m = '0; ack_s = '0;
        check("R2/R3/R7/R9 machine irq", 32'(irq_m), 32'(exp_m));
        check("R2/R4/R7/R8 supervisor irq", 32'(irq_s), 32'(exp_s));
        if (req && !we) begin
            check("R5/R7 machine readback", rdata_m, exp_rm);
            check("R6 supervisor readback", rdata_s, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_m = '0;
        exp_s = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset irq machine", 32'(irq_m), 32'h0);
        check("R1 reset irq supervisor", 32'(irq_s), 32'h0);
        check("R1 reset rdata", rdata_m | rdata_s, 32'h0);

        // R2 R3 R4 R5 R6 R7: sweep every offset with bit0 set then clear, junk upper bits
        for (int a = 0; a < (1 << AW); a++) begin
            step(1, 1, a, {a[15:0], 15'h5A5A, 1'b1}, 4'hF, '0, '0);
            step(1, 0, a, 32'h0, 4'hF, '0, '0);
            step(1, 1, a, {16'hFFFF, a[14:0], 1'b0}, 4'hF, '0, '0);
            step(1, 0, a, 32'h0, 4'hF, '0, '0);
        end

        // R7: partial byte enables ignored
        step(0, 0, 0, 0, 4'hF, '0, 4'hF);
        for (int b = 0; b < 15; b++) begin
            step(1, 1, 4, 32'h1, 4'(b), '0, '0);
            step(1, 0, 4, 32'h0, 4'(b), '0, '0);
        end

        // R9 and R8: raise all lanes, acknowledge all
        for (int i = 0; i < N; i++) step(1, 1, 4*i, 32'h1, 4'hF, '0, '0);
        step(0, 0, 0, 0, 4'hF, 4'hF, '0);   // R9: machine ignores ack
        step(0, 0, 0, 0, 4'hF, '0, 4'b0101); // R8: supervisor lanes 0,2 clear
        step(1, 1, 4, 32'h1, 4'hF, '0, 4'b0010); // R8: set wins on lane 1
        step(1, 1, 0, 32'h1, 4'hF, '0, 4'b1000); // R8: set lane 0 while ack lane 3
        for (int i = 0; i < N; i++) step(1, 0, 4*i, 0, 4'hF, 4'hF, '0); // R5 R9 readback
        step(0, 0, 0, 0, 4'hF, '0, 4'hF);
        check("R8 all supervisor lanes acknowledged", 32'(irq_s), 32'h0);
        check("R7 idle rdata zero", rdata_m, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule